// File: doc/BRIEF.md
# Set-Indexed, Physically-Tagged L1 Data Cache Lookup

This block is the tag and data lookup path of a set-associative first-level data cache. It picks the set from address bits that sit inside the page offset, so those bits are the same before and after translation. The indexed set can therefore be read in the cycle the lookup is issued, while address translation runs alongside it. One cycle later the translation answers with a physical page number. That number is compared with the physical tags held in every way of the set. The result is a hit flag, the way that hit and the full line.

Since the index needs no translation and the tags are physical, the cache acts like a physically addressed array. Two virtual addresses that map to one physical line find the same entry. Two address spaces that use the same virtual address for different physical pages never confuse each other, and no per-thread or per-process tag is needed.

A lookup that misses only reports the miss. Lines enter through a fill port, which places them in a victim way chosen by a tree pseudo-LRU per set. An invalidate port removes a line given its physical line address.

None of the interfaces exerts back-pressure, so none has a ready signal. A lookup, a fill and an invalidate are all accepted in any cycle, and all three may be presented in the same cycle. The response is valid for exactly one cycle, and the consumer must capture it in that cycle.

With the default parameters the cache holds 32 KiB as 8 ways of 64-byte lines in 64 sets, with 4 KiB pages and a 36-bit physical address.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset no line is valid, rs_valid, rs_hit and rs_miss are low, and every set's pseudo-LRU state is all zero.
- R2: rs_valid is high in exactly the cycle after a cycle with lk_valid high. xl_ppn is sampled in that response cycle.
- R3: The set is lk_vaddr[11:6], and lk_vaddr bits above 11 have no effect. Two lookups that differ only in those bits, with the same xl_ppn, hit the same way and return the same data.
- R4: A lookup hits only if a valid way of the set holds a tag equal to xl_ppn. The same virtual address presented with a different xl_ppn misses.
- R5: During rs_valid exactly one of rs_hit and rs_miss is high. On a miss rs_way is 0 and rs_data is all zero.
- R6: For any lookup, at most one way matches.
- R7: A fill takes the physical line address fl_pline, whose bits [5:0] are the set and whose bits [29:6] are the tag. If that tag is already valid in the set, the fill overwrites that way in place and no second copy is made.
- R8: Otherwise the fill writes the way the tree pseudo-LRU selects. Node n has children 2n and 2n+1, its bit at 0 points left, and leaves 0..7 are ways 0..7. With all bits at 0, eight fills of new tags land in ways 0, 4, 2, 6, 1, 5, 3, 7.
- R9: A hit and a fill each set every tree node on the path of the way they touch so that it points away from that way.
- R10: An invalidate clears the valid bit only of the line whose set and tag both equal iv_pline. Other lines in the same set, and the same tag in other sets, stay valid.
- R11: A fill or invalidate presented in cycle t is seen by lookups issued in cycle t+1 or later. A lookup issued in cycle t sees the contents from before that write.
- R12: On a hit, rs_data equals the data of the most recent fill of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup issued this cycle |
| lk_vaddr | input | 48 | Virtual address of the lookup |
| xl_ppn | input | 24 | Translated physical page number, valid in the response cycle |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Lookup hit |
| rs_miss | output | 1 | Lookup missed |
| rs_way | output | 3 | Way that hit, 0 on a miss |
| rs_data | output | 512 | Line that hit, zero on a miss |
| fl_valid | input | 1 | Fill request |
| fl_pline | input | 30 | Physical line address of the fill |
| fl_data | input | 512 | Line contents of the fill |
| iv_valid | input | 1 | Invalidate request |
| iv_pline | input | 30 | Physical line address to invalidate |

## Verification
The single-match property depends on every valid tag in a set being unique. The fill port ensures this by reusing a way that already holds the tag, so the stimulus may refill a line that is already present and still keeps the property intact. The response-timing properties assume that xl_ppn is driven in the cycle after the lookup, and the bench always drives it in that cycle. The bench drives a lookup and a fill in the same cycle to exercise the write-visibility rule. It never requests a fill and an invalidate of the same line in the same cycle, because the block gives no ordering guarantee for that case.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int DEF_PA_W        = 36;
  localparam int DEF_VA_W        = 48;
  localparam int DEF_CACHE_BYTES = 32768;
  localparam int DEF_WAYS        = 8;
  localparam int DEF_LINE_BYTES  = 64;
  localparam int DEF_PAGE_BYTES  = 4096;
endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 24,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            vld,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            match_vec,
  output logic                       any,
  output logic [WAY_W-1:0]           way_idx
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = vld[w] && (tags[w] == key);
  end

  assign any = |match_vec;

  always_comb begin
    way_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) way_idx = way_idx | WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fl_en,
  input  logic [SET_W-1:0] fl_set,
  input  logic [WAY_W-1:0] fl_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAYS-2:0] tree_q [SETS];

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] st,
                                            input logic [WAY_W-1:0] w);
    int   node;
    logic b;
    touch = st;
    node  = 1;
    for (int l = 0; l < WAY_W; l++) begin
      b = w[WAY_W-1-l];
      touch[node-1] = ~b;
      node = 2 * node + int'(b);
    end
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] st);
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      node = 2 * node + int'(st[node-1]);
    end
    pick = WAY_W'(node - WAYS);
  endfunction

  assign victim = pick(tree_q[q_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (hit_en && fl_en && (hit_set == fl_set)) begin
      tree_q[fl_set] <= touch(touch(tree_q[fl_set], hit_way), fl_way);
    end else begin
      if (hit_en) tree_q[hit_set] <= touch(tree_q[hit_set], hit_way);
      if (fl_en)  tree_q[fl_set]  <= touch(tree_q[fl_set], fl_way);
    end
  end
endmodule

// File: rtl/vipt_arrays.sv
module vipt_arrays #(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 512,
  parameter int SET_W  = 6,
  parameter int WAY_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_vld,
  output logic [WAYS-1:0][LINE_W-1:0] rd_data,
  input  logic [SET_W-1:0]            pr_set,
  output logic [WAYS-1:0][TAG_W-1:0]  pr_tag,
  output logic [WAYS-1:0]             pr_vld,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [LINE_W-1:0]           wr_data,
  input  logic                        iv_en,
  input  logic [SET_W-1:0]            iv_set,
  input  logic [TAG_W-1:0]            iv_tag
);
  logic [WAYS-1:0][TAG_W-1:0]  tag_mem [SETS];
  logic [WAYS-1:0][LINE_W-1:0] dat_mem [SETS];
  logic [WAYS-1:0]             vld_mem [SETS];

  assign pr_tag = tag_mem[pr_set];
  assign pr_vld = vld_mem[pr_set];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set][wr_way] <= wr_tag;
      dat_mem[wr_set][wr_way] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else begin
      if (wr_en) vld_mem[wr_set][wr_way] <= 1'b1;
      if (iv_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (vld_mem[iv_set][w] && (tag_mem[iv_set][w] == iv_tag))
            vld_mem[iv_set][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_data <= dat_mem[rd_set];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_vld <= '0;
    else if (rd_en) rd_vld <= vld_mem[rd_set];
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int PA_W        = DEF_PA_W,
  parameter int VA_W        = DEF_VA_W,
  parameter int CACHE_BYTES = DEF_CACHE_BYTES,
  parameter int WAYS        = DEF_WAYS,
  parameter int LINE_BYTES  = DEF_LINE_BYTES,
  parameter int PAGE_BYTES  = DEF_PAGE_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int PG_W    = $clog2(PAGE_BYTES),
  localparam int SETS    = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int PPN_W   = PA_W - PG_W,
  localparam int PLINE_W = PA_W - OFF_W,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic [PPN_W-1:0]   xl_ppn,
  output logic               rs_valid,
  output logic               rs_hit,
  output logic               rs_miss,
  output logic [WAY_W-1:0]   rs_way,
  output logic [LINE_W-1:0]  rs_data,
  input  logic               fl_valid,
  input  logic [PLINE_W-1:0] fl_pline,
  input  logic [LINE_W-1:0]  fl_data,
  input  logic               iv_valid,
  input  logic [PLINE_W-1:0] iv_pline
);
  // Stage 1: index from page-offset bits only
  logic [SET_W-1:0] lk_set;
  logic             unused_va;
  assign lk_set    = lk_vaddr[PG_W-1:OFF_W];
  assign unused_va = ^{lk_vaddr[VA_W-1:PG_W], lk_vaddr[OFF_W-1:0]};

  logic [SET_W-1:0] fl_set, iv_set;
  logic [PPN_W-1:0] fl_tag, iv_tag;
  assign fl_set = fl_pline[SET_W-1:0];
  assign fl_tag = fl_pline[PLINE_W-1:SET_W];
  assign iv_set = iv_pline[SET_W-1:0];
  assign iv_tag = iv_pline[PLINE_W-1:SET_W];

  logic [WAYS-1:0][PPN_W-1:0]  s1_tag, pr_tag;
  logic [WAYS-1:0]             s1_vld, pr_vld;
  logic [WAYS-1:0][LINE_W-1:0] s1_data;
  logic                        s1_valid;
  logic [SET_W-1:0]            s1_set;

  // Fill way selection
  logic [WAY_W-1:0] fl_victim, pr_way, fl_way;
  logic [WAYS-1:0]  pr_match;
  logic             pr_hit;

  vipt_arrays #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W), .LINE_W(LINE_W),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .rd_en(lk_valid), .rd_set(lk_set),
    .rd_tag(s1_tag), .rd_vld(s1_vld), .rd_data(s1_data),
    .pr_set(fl_set), .pr_tag(pr_tag), .pr_vld(pr_vld),
    .wr_en(fl_valid), .wr_set(fl_set), .wr_way(fl_way),
    .wr_tag(fl_tag), .wr_data(fl_data),
    .iv_en(iv_valid), .iv_set(iv_set), .iv_tag(iv_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_set   <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) s1_set <= lk_set;
    end
  end

  // Stage 2: compare with translated page number
  logic [WAYS-1:0]  match_vec;
  logic             lk_any;
  logic [WAY_W-1:0] lk_way;

  vipt_way_match #(.WAYS(WAYS), .TAG_W(PPN_W), .WAY_W(WAY_W)) u_cmp (
    .tags(s1_tag), .vld(s1_vld), .key(xl_ppn),
    .match_vec(match_vec), .any(lk_any), .way_idx(lk_way)
  );

  vipt_way_match #(.WAYS(WAYS), .TAG_W(PPN_W), .WAY_W(WAY_W)) u_probe (
    .tags(pr_tag), .vld(pr_vld), .key(fl_tag),
    .match_vec(pr_match), .any(pr_hit), .way_idx(pr_way)
  );

  assign fl_way = pr_hit ? pr_way : fl_victim;

  logic hit_now;
  assign hit_now  = s1_valid && lk_any;
  assign rs_valid = s1_valid;
  assign rs_hit   = hit_now;
  assign rs_miss  = s1_valid && !lk_any;
  assign rs_way   = hit_now ? lk_way : '0;
  assign rs_data  = hit_now ? s1_data[lk_way] : '0;

  vipt_plru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .hit_en(hit_now), .hit_set(s1_set), .hit_way(lk_way),
    .fl_en(fl_valid), .fl_set(fl_set), .fl_way(fl_way),
    .q_set(fl_set), .victim(fl_victim)
  );
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_miss,
  input logic [WAY_W-1:0] rs_way,
  input logic [WAYS-1:0]  match_vec
);
  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot0(match_vec));

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  assert_hit_xor_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_hit != rs_miss));

  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (!rs_hit && !rs_miss));

  assert_miss_way_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> (rs_way == '0));
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rs_valid(rs_valid),
  .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_way(rs_way), .match_vec(match_vec)
);

// File: tb/tb_vipt_l1_lookup.sv
module tb_vipt_l1_lookup;
  localparam int VA_W = 48;
  localparam int HI_W = VA_W - 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lk_valid = 1'b0;
  logic [47:0]  lk_vaddr = '0;
  logic [23:0]  xl_ppn = '0;
  logic         rs_valid, rs_hit, rs_miss;
  logic [2:0]   rs_way;
  logic [511:0] rs_data;
  logic         fl_valid = 1'b0;
  logic [29:0]  fl_pline = '0;
  logic [511:0] fl_data = '0;
  logic         iv_valid = 1'b0;
  logic [29:0]  iv_pline = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vipt_l1_lookup dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .xl_ppn(xl_ppn), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_way(rs_way), .rs_data(rs_data), .fl_valid(fl_valid),
    .fl_pline(fl_pline), .fl_data(fl_data), .iv_valid(iv_valid),
    .iv_pline(iv_pline)
  );

  function automatic logic [511:0] pat(input logic [23:0] tag, input int set);
    logic [31:0] w;
    w = {2'b10, tag, 6'(set)};
    return {16{w}};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [HI_W-1:0] hi, input int set,
                      input logic [23:0] ppn, input bit eh, input int ew,
                      input logic [511:0] ed, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {hi, 6'(set), 6'h2A};
    @(negedge clk);
    lk_valid = 1'b0;
    xl_ppn   = ppn;
    #1;
    check(req, "rs_valid", 512'(rs_valid), 512'(1));
    check(req, "rs_hit",   512'(rs_hit),   512'(eh));
    check(req, "rs_miss",  512'(rs_miss),  512'(!eh));
    check(req, "rs_way",   512'(rs_way),   512'(ew));
    check(req, "rs_data",  rs_data,        ed);
  endtask

  task automatic fill(input logic [23:0] tag, input int set,
                      input logic [511:0] d);
    @(negedge clk);
    fl_valid = 1'b1;
    fl_pline = {tag, 6'(set)};
    fl_data  = d;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic inval(input logic [23:0] tag, input int set);
    @(negedge clk);
    iv_valid = 1'b1;
    iv_pline = {tag, 6'(set)};
    @(negedge clk);
    iv_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1", "rs_valid at reset", 512'(rs_valid), 512'(0));
    check("R1", "rs_hit at reset",   512'(rs_hit),   512'(0));
    look(36'h0, 3, 24'h0, 1'b0, 0, '0, "R1");
  endtask

  task automatic t_timing();
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = 48'h40;
    #1;
    check("R2", "rs_valid in issue cycle", 512'(rs_valid), 512'(0));
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    check("R2", "rs_valid next cycle", 512'(rs_valid), 512'(1));
    @(negedge clk);
    #1;
    check("R2", "rs_valid drops", 512'(rs_valid), 512'(0));
  endtask

  task automatic t_alias();
    fill(24'h123, 5, pat(24'h123, 5));
    look(36'h1, 5, 24'h123, 1'b1, 0, pat(24'h123, 5), "R3 R12");
    look(36'hABCDE, 5, 24'h123, 1'b1, 0, pat(24'h123, 5), "R3 synonym");
    look(36'h1, 6, 24'h123, 1'b0, 0, '0, "R3 other set");
    look(36'h1, 5, 24'h124, 1'b0, 0, '0, "R4 homonym");
  endtask

  task automatic t_plru();
    int ord[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    for (int i = 0; i < 8; i++) fill(24'h900 + 24'(i), 9, pat(24'h900 + 24'(i), 9));
    for (int i = 0; i < 8; i++)
      look(36'h7, 9, 24'h900 + 24'(i), 1'b1, ord[i], pat(24'h900 + 24'(i), 9), "R8");
    look(36'h7, 9, 24'h900, 1'b1, 0, pat(24'h900, 9), "R9 touch way0");
    fill(24'h9FF, 9, pat(24'h9FF, 9));
    look(36'h7, 9, 24'h9FF, 1'b1, 4, pat(24'h9FF, 9), "R9 victim after hit");
    look(36'h7, 9, 24'h901, 1'b0, 0, '0, "R9 evicted line");
  endtask

  task automatic t_refill();
    fill(24'h900, 9, ~pat(24'h900, 9));
    look(36'h3, 9, 24'h900, 1'b1, 0, ~pat(24'h900, 9), "R7 in-place refill");
    look(36'h3, 9, 24'h9FF, 1'b1, 4, pat(24'h9FF, 9), "R7 neighbour kept");
  endtask

  task automatic t_inval();
    fill(24'h456, 5, pat(24'h456, 5));
    look(36'h2, 5, 24'h456, 1'b1, 4, pat(24'h456, 5), "R10 setup");
    inval(24'h789, 5);
    look(36'h2, 5, 24'h123, 1'b1, 0, pat(24'h123, 5), "R10 no match kept");
    inval(24'h456, 6);
    look(36'h2, 5, 24'h456, 1'b1, 4, pat(24'h456, 5), "R10 other set kept");
    inval(24'h123, 5);
    look(36'h2, 5, 24'h123, 1'b0, 0, '0, "R10 cleared");
    look(36'h2, 5, 24'h456, 1'b1, 4, pat(24'h456, 5), "R10 sibling kept");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {36'h5, 6'd20, 6'h0};
    fl_valid = 1'b1;
    fl_pline = {24'hCAB, 6'd20};
    fl_data  = pat(24'hCAB, 20);
    @(negedge clk);
    lk_valid = 1'b0;
    fl_valid = 1'b0;
    xl_ppn   = 24'hCAB;
    #1;
    check("R11", "same-cycle lookup misses", 512'(rs_miss), 512'(1));
    look(36'h5, 20, 24'hCAB, 1'b1, 0, pat(24'hCAB, 20), "R11 later lookup");
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_alias();
    t_plru();
    t_refill();
    t_inval();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule